// File: doc/BRIEF.md
# Sub-Width Aliased Register File

This block holds a bank of general-purpose integer registers with two read ports and one write port. Every access names a register and an access width. The width can be the full 64 bits, the low 32 bits, the low 16 bits, the low byte, or the second byte (bits 15:8). A write merges into the stored value according to its width. A 32-bit write zeroes the upper half of the register. A 16-bit or byte write leaves every untouched bit as it was. A read returns the selected slice, right-aligned and zero-extended.

The second-byte view exists only for the first four registers. Any access that uses it on a higher register, or that uses an unassigned width code, raises an illegal-access flag. Such a write leaves the bank unchanged and such a read returns zero. Read data and all flags are registered, so they appear one cycle after the request. The full contents of every register are also driven onto a flat debug bus.

Top module: `alias_regfile`

## Requirements
- R1: While reset is high, every register, both read data outputs and all three illegal flags are driven to zero on the next clock edge.
- R2: A write with width code 0 (64-bit) replaces all 64 bits of the addressed register.
- R3: A write with width code 1 (32-bit) stores wr_data[31:0] in bits 31:0 and forces bits 63:32 to zero.
- R4: A write with width code 2 (16-bit) replaces only bits 15:0. A write with width code 3 (low byte) replaces only bits 7:0. All other bits keep their previous value.
- R5: A write with width code 4 (second byte) to register 0, 1, 2 or 3 copies wr_data[7:0] into bits 15:8 and keeps all other bits.
- R6: One cycle after a read request, the port returns the selected slice zero-extended to 64 bits. Width code 0 gives the whole value, 1 gives bits 31:0, 2 gives bits 15:0, 3 gives bits 7:0, and 4 gives bits 15:8 placed in bits 7:0.
- R7: An access with width code 4 to registers 4 to 15, or with width code 5, 6 or 7, is illegal. One cycle later the matching illegal flag is high. An illegal write changes no register, and an illegal read returns zero.
- R8: When a read and a write address the same register in the same cycle, the read returns the value from before the write.
- R9: A write changes only the addressed register, and nothing changes while wr_en is low.
- R10: dbg_regs bits [64*i+63:64*i] show register i and reflect a write from the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Register written |
| wr_size | input | 3 | Write width code |
| wr_data | input | 64 | Write value, right-aligned |
| wr_illegal | output | 1 | Previous write request was illegal |
| rd_a_idx | input | 4 | Port A register |
| rd_a_size | input | 3 | Port A width code |
| rd_a_data | output | 64 | Port A slice, zero-extended |
| rd_a_illegal | output | 1 | Port A request was illegal |
| rd_b_idx | input | 4 | Port B register |
| rd_b_size | input | 3 | Port B width code |
| rd_b_data | output | 64 | Port B slice, zero-extended |
| rd_b_illegal | output | 1 | Port B request was illegal |
| dbg_regs | output | 1024 | All registers, register i at bits 64*i upward |

## Verification
The bench builds the block with its default parameters: sixteen 64-bit registers, four of which have a second-byte view. With these values, random register indices reach both sides of the second-byte boundary and hit all five width codes and the three reserved ones. Read-write collisions on the same register also occur often. Directed steps put every width rule on a register whose upper bits are all ones, so that cleared and preserved bits differ visibly.

// File: rtl/alias_pkg.sv
package alias_pkg;
  typedef enum logic [2:0] {
    SZ_FULL = 3'd0,
    SZ_WORD = 3'd1,
    SZ_HALF = 3'd2,
    SZ_LOB  = 3'd3,
    SZ_HIB  = 3'd4
  } acc_size_e;

  function automatic logic access_ok(input logic [2:0] size, input int unsigned idx,
                                     input int unsigned hib_regs);
    if (size <= 3'd3) return 1'b1;
    if (size == 3'd4) return idx < hib_regs;
    return 1'b0;
  endfunction
endpackage

// File: rtl/alias_merge.sv
module alias_merge #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] wdata,
  input  logic [2:0]      size,
  input  logic            ok,
  output logic [XLEN-1:0] new_val
);
  import alias_pkg::*;
  localparam int HALF = XLEN / 2;

  always_comb begin
    new_val = old_val;
    if (ok) begin
      case (size)
        SZ_FULL: new_val = wdata;
        SZ_WORD: begin
          new_val = '0;
          new_val[HALF-1:0] = wdata[HALF-1:0];
        end
        SZ_HALF: new_val[15:0] = wdata[15:0];
        SZ_LOB:  new_val[7:0]  = wdata[7:0];
        SZ_HIB:  new_val[15:8] = wdata[7:0];
        default: new_val = old_val;
      endcase
    end
  end
endmodule

// File: rtl/alias_slice.sv
module alias_slice #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] val,
  input  logic [2:0]      size,
  input  logic            ok,
  output logic [XLEN-1:0] slice
);
  import alias_pkg::*;
  localparam int HALF = XLEN / 2;

  always_comb begin
    slice = '0;
    if (ok) begin
      case (size)
        SZ_FULL: slice = val;
        SZ_WORD: slice[HALF-1:0] = val[HALF-1:0];
        SZ_HALF: slice[15:0] = val[15:0];
        SZ_LOB:  slice[7:0]  = val[7:0];
        SZ_HIB:  slice[7:0]  = val[15:8];
        default: slice = '0;
      endcase
    end
  end
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile #(
  parameter int NREG     = 16,
  parameter int XLEN     = 64,
  parameter int HIB_REGS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [3:0]           wr_idx,
  input  logic [2:0]           wr_size,
  input  logic [63:0]          wr_data,
  output logic                 wr_illegal,
  input  logic [3:0]           rd_a_idx,
  input  logic [2:0]           rd_a_size,
  output logic [63:0]          rd_a_data,
  output logic                 rd_a_illegal,
  input  logic [3:0]           rd_b_idx,
  input  logic [2:0]           rd_b_size,
  output logic [63:0]          rd_b_data,
  output logic                 rd_b_illegal,
  output logic [1023:0]        dbg_regs
);
  import alias_pkg::*;
  localparam int IDX_W = $clog2(NREG);
  localparam int NRD   = 2;
  localparam int HALF  = XLEN / 2;

  logic [XLEN-1:0] regs [NREG];
  logic [XLEN-1:0] merged;
  logic            wr_ok;

  assign wr_ok = access_ok(wr_size, int'(wr_idx), HIB_REGS);

  alias_merge #(.XLEN(XLEN)) u_merge (
    .old_val(regs[wr_idx[IDX_W-1:0]]),
    .wdata  (wr_data),
    .size   (wr_size),
    .ok     (wr_ok),
    .new_val(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      wr_illegal <= 1'b0;
    end else begin
      if (wr_en && wr_ok) regs[wr_idx[IDX_W-1:0]] <= merged;
      wr_illegal <= wr_en && !wr_ok;
    end
  end

  // read ports
  logic [IDX_W-1:0] rd_idx  [NRD];
  logic [2:0]       rd_size [NRD];
  logic [XLEN-1:0]  rd_q    [NRD];
  logic             rd_bad  [NRD];

  assign rd_idx[0]  = rd_a_idx[IDX_W-1:0];
  assign rd_idx[1]  = rd_b_idx[IDX_W-1:0];
  assign rd_size[0] = rd_a_size;
  assign rd_size[1] = rd_b_size;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic            ok;
    logic [XLEN-1:0] sl;
    assign ok = access_ok(rd_size[p], int'(rd_idx[p]), HIB_REGS);
    alias_slice #(.XLEN(XLEN)) u_slice (
      .val  (regs[rd_idx[p]]),
      .size (rd_size[p]),
      .ok   (ok),
      .slice(sl)
    );
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_q[p]   <= '0;
        rd_bad[p] <= 1'b0;
      end else begin
        rd_q[p]   <= sl;
        rd_bad[p] <= !ok;
      end
    end
  end

  assign rd_a_data    = rd_q[0];
  assign rd_b_data    = rd_q[1];
  assign rd_a_illegal = rd_bad[0];
  assign rd_b_illegal = rd_bad[1];

  for (genvar i = 0; i < NREG; i++) begin : g_dbg
    assign dbg_regs[i*XLEN +: XLEN] = regs[i];

    // R9: registers other than the legally written one hold their value
    assert_untouched_R9: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_ok && wr_idx == i) |=> $stable(regs[i]));
  end

  // R1: outputs are cleared after a reset cycle
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (rd_a_data == '0 && rd_b_data == '0 && !wr_illegal));

  // R3: a 32-bit write leaves the upper half zero
  assert_word_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == 3'd1) |=> regs[$past(wr_idx[IDX_W-1:0])][XLEN-1:HALF] == '0);

  // R4: a 16-bit write keeps bits above 15
  assert_half_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == 3'd2) |=>
      regs[$past(wr_idx[IDX_W-1:0])][XLEN-1:16] == $past(regs[wr_idx[IDX_W-1:0]][XLEN-1:16]));

  // R7: an illegal write leaves its target unchanged and is flagged
  assert_bad_write_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_ok) |=>
      (wr_illegal && regs[$past(wr_idx[IDX_W-1:0])] == $past(regs[wr_idx[IDX_W-1:0]])));

  // R7: an illegal read returns zero
  assert_bad_read_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_a_illegal |-> rd_a_data == '0) and (rd_b_illegal |-> rd_b_data == '0));
endmodule

// File: tb/test_alias_regfile.sv
module test_alias_regfile;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [3:0]   wr_idx = '0;
  logic [2:0]   wr_size = '0;
  logic [63:0]  wr_data = '0;
  logic         wr_illegal;
  logic [3:0]   rd_a_idx = '0, rd_b_idx = '0;
  logic [2:0]   rd_a_size = '0, rd_b_size = '0;
  logic [63:0]  rd_a_data, rd_b_data;
  logic         rd_a_illegal, rd_b_illegal;
  logic [1023:0] dbg_regs;

  int n_run = 0;
  int n_fail = 0;
  logic [63:0] model [16];

  always #10 clk = ~clk;

  alias_regfile i_alias_regfile (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size),
    .wr_data(wr_data), .wr_illegal(wr_illegal),
    .rd_a_idx(rd_a_idx), .rd_a_size(rd_a_size), .rd_a_data(rd_a_data),
    .rd_a_illegal(rd_a_illegal),
    .rd_b_idx(rd_b_idx), .rd_b_size(rd_b_size), .rd_b_data(rd_b_data),
    .rd_b_illegal(rd_b_illegal), .dbg_regs(dbg_regs)
  );

  function automatic logic legal(input int sz, input int idx);
    return (sz <= 3) || (sz == 4 && idx < 4);
  endfunction

  function automatic logic [63:0] exp_merge(input logic [63:0] o, input logic [63:0] d, input int sz);
    case (sz)
      0: return d;
      1: return {32'b0, d[31:0]};
      2: return {o[63:16], d[15:0]};
      3: return {o[63:8], d[7:0]};
      4: return {o[63:16], d[7:0], o[7:0]};
      default: return o;
    endcase
  endfunction

  function automatic logic [63:0] exp_slice(input logic [63:0] v, input int sz);
    case (sz)
      0: return v;
      1: return {32'b0, v[31:0]};
      2: return {48'b0, v[15:0]};
      3: return {56'b0, v[7:0]};
      4: return {56'b0, v[15:8]};
      default: return 64'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string rd_tag(input int sz, input int idx, input logic we, input int widx, input int wsz);
    if (!legal(sz, idx)) return "R7 read";
    if (we && widx == idx && legal(wsz, widx)) return "R8 read";
    return "R6 read";
  endfunction

  function automatic string wr_tag(input logic we, input int sz, input int idx);
    if (!we) return "R9 no write";
    if (!legal(sz, idx)) return "R7 write";
    case (sz)
      0: return "R2 write";
      1: return "R3 write";
      2: return "R4 write";
      3: return "R4 write";
      default: return "R5 write";
    endcase
  endfunction

  task automatic op(input logic we, input int widx, input int wsz, input logic [63:0] wd,
                    input int ai, input int asz, input int bi, input int bsz);
    logic [63:0] ea, eb;
    logic ewi;
    string ta, tb, tw;
    @(negedge clk);
    wr_en = we; wr_idx = 4'(widx); wr_size = 3'(wsz); wr_data = wd;
    rd_a_idx = 4'(ai); rd_a_size = 3'(asz);
    rd_b_idx = 4'(bi); rd_b_size = 3'(bsz);
    ea = exp_slice(model[ai], legal(asz, ai) ? asz : 7);
    eb = exp_slice(model[bi], legal(bsz, bi) ? bsz : 7);
    ewi = we && !legal(wsz, widx);
    ta = rd_tag(asz, ai, we, widx, wsz);
    tb = rd_tag(bsz, bi, we, widx, wsz);
    tw = wr_tag(we, wsz, widx);
    if (we && legal(wsz, widx)) model[widx] = exp_merge(model[widx], wd, wsz);
    @(posedge clk);
    #2;
    chk({ta, " port A"}, rd_a_data, ea);
    chk({tb, " port B"}, rd_b_data, eb);
    chk({"R7 flag A"}, {63'b0, rd_a_illegal}, {63'b0, !legal(asz, ai)});
    chk({"R7 flag B"}, {63'b0, rd_b_illegal}, {63'b0, !legal(bsz, bi)});
    chk({"R7 flag write"}, {63'b0, wr_illegal}, {63'b0, ewi});
    for (int i = 0; i < 16; i++) chk({tw, " R10 dbg"}, dbg_regs[i*64 +: 64], model[i]);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1 rd A", rd_a_data, 0);
    chk("R1 rd B", rd_b_data, 0);
    chk("R1 flags", {61'b0, wr_illegal, rd_a_illegal, rd_b_illegal}, 0);
    chk("R1 dbg", dbg_regs[63:0] | dbg_regs[1023:960], 0);
    @(negedge clk);
    rst = 1'b0;

    // fill every register with all ones (R2)
    for (int i = 0; i < 16; i++) op(1, i, 0, 64'hFFFF_FFFF_FFFF_FFFF, i, 0, 0, 0);
    op(1, 5, 1, 64'h1234_5678_9ABC_DEF0, 5, 0, 5, 1);     // R3
    op(0, 0, 0, 0, 5, 0, 5, 1);                           // R3 readback
    op(1, 6, 2, 64'h0000_0000_0000_A5A5, 6, 0, 6, 2);     // R4 16-bit
    op(1, 7, 3, 64'h0000_0000_0000_003C, 7, 0, 7, 3);     // R4 low byte
    op(1, 2, 4, 64'h0000_0000_0000_0042, 2, 0, 2, 4);     // R5
    op(0, 0, 0, 0, 2, 0, 2, 4);                           // R5/R6 readback
    op(1, 3, 4, 64'h0000_0000_0000_0011, 3, 4, 3, 3);     // R5 last legal reg
    op(1, 4, 4, 64'h0000_0000_0000_0000, 4, 4, 9, 4);     // R7 boundary reg 4
    op(1, 9, 6, 64'h0, 9, 5, 9, 7);                       // R7 reserved codes
    op(0, 4, 4, 0, 4, 0, 9, 0);                           // R7 targets unchanged
    op(1, 8, 0, 64'hDEAD_BEEF_0000_0001, 8, 0, 8, 1);     // R8 collision
    op(0, 8, 0, 64'h5555, 8, 0, 8, 2);                    // R9 wr_en low

    seed = 32'd20240611;
    void'($urandom(seed));
    for (int n = 0; n < 3000; n++) begin
      op(1'($urandom_range(0, 1)), $urandom_range(0, 15), $urandom_range(0, 7),
         {$urandom, $urandom}, $urandom_range(0, 15), $urandom_range(0, 7),
         $urandom_range(0, 15), $urandom_range(0, 7));
    end

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    @(posedge clk);
    #2;
    for (int i = 0; i < 16; i++) begin
      model[i] = '0;
      chk("R1 dbg after reset", dbg_regs[i*64 +: 64], 0);
    end
    chk("R1 rd A after reset", rd_a_data, 0);
    @(negedge clk);
    rst = 1'b0;
    op(0, 0, 0, 0, 0, 0, 15, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule